// File: doc/BRIEF.md
# Single-Precision Float Unpack Unit

This block splits a 32-bit single-precision floating-point bit pattern into two integer words that software floating-point routines can work on directly: an unbiased exponent as a 32-bit two's-complement value (the high word of the result pair) and a left-aligned mantissa (the low word). Encoded fraction bits are moved up by seven places so that a normal number's implicit leading one lands at mantissa bit 30. Bit 31 of the mantissa stays free for carries. The sign of the input is dropped. Neither the exponent nor the mantissa depends on it.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream after one register stage. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This lets a new operand replace a consumed result with no bubble. While the consumer holds `out_ready` low, the pending result and its valid are frozen and no new operand is accepted. Rounding, renormalisation of subnormals and NaN classification are left to the software that uses the words.

Top module: `fp_unpack_unit`

## Requirements
- R1: An operand whose exponent field (bits 30:23) is 255 gives exponent 255 and mantissa equal to the fraction field (bits 22:0) shifted left by 7, with bit 30 clear.
- R2: An operand whose exponent and fraction fields are both zero gives exponent -127 (0xFFFFFF81) and mantissa 0.
- R3: An operand with a zero exponent field and a nonzero fraction gives exponent -126 (0xFFFFFF82) and mantissa equal to the fraction shifted left by 7, with bit 30 clear.
- R4: Any other operand gives exponent equal to the exponent field minus 127, sign-extended to 32 bits, and mantissa equal to the fraction shifted left by 7 with bit 30 set.
- R5: Input bit 31 has no effect on either output word. Mantissa bit 31 and bits 6:0 are always zero.
- R6: An operand accepted on a clock edge appears on the outputs with `out_valid` high immediately after that edge. `out_valid` falls after an edge where the result is consumed and no new operand is accepted.
- R7: While `out_valid` is high and `out_ready` is low, the outputs and `out_valid` hold their values and `in_ready` is low. `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R8: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present on `in_operand` |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_operand | input | 32 | Single-precision bit pattern |
| out_valid | output | 1 | Result present on the output words |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_exponent | output | 32 | Unbiased exponent, two's complement (high word) |
| out_mantissa | output | 32 | Aligned mantissa (low word) |

## Verification
All 256 exponent field values are swept against zero, unit, all-ones, top-bit-only and alternating fractions, each with both sign values. The zero and nonzero fractions at field 0 separate the zero case from the subnormal case. Field 255 and fields 1 to 254 separate the special class from the normal class by the hidden bit and the exponent formula. Pairs that differ only in the sign bit must produce identical words. A separate sequence holds `out_ready` low while a second operand waits, showing that the result is held, that nothing is overwritten, and that the waiting operand follows once the stall ends.

// File: rtl/fp_unpack_pkg.sv
package fp_unpack_pkg;
  // Operand classes decided from the exponent and fraction fields
  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUBNORM = 2'd1,
    CLS_NORMAL  = 2'd2,
    CLS_SPECIAL = 2'd3
  } op_class_e;
endpackage

// File: rtl/fp_field_decode.sv
module fp_field_decode
  import fp_unpack_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] magnitude,
  output logic [EXP_W-1:0]        exp_field,
  output logic [FRAC_W-1:0]       frac_field,
  output op_class_e               op_class
);
  assign exp_field  = magnitude[FRAC_W +: EXP_W];
  assign frac_field = magnitude[FRAC_W-1:0];

  always_comb begin
    if (&exp_field)
      op_class = CLS_SPECIAL;
    else if (exp_field == '0)
      op_class = (frac_field == '0) ? CLS_ZERO : CLS_SUBNORM;
    else
      op_class = CLS_NORMAL;
  end
endmodule

// File: rtl/fp_value_build.sv
module fp_value_build
  import fp_unpack_pkg::*;
#(
  parameter int EXP_W      = 8,
  parameter int FRAC_W     = 23,
  parameter int OUT_W      = 32,
  parameter int HIDDEN_POS = 30
) (
  input  op_class_e          op_class,
  input  logic [EXP_W-1:0]   exp_field,
  input  logic [FRAC_W-1:0]  frac_field,
  output logic [OUT_W-1:0]   exponent,
  output logic [OUT_W-1:0]   mantissa
);
  localparam int ALIGN = HIDDEN_POS - FRAC_W;
  localparam logic signed [OUT_W-1:0] BIAS = OUT_W'((1 << (EXP_W - 1)) - 1);
  localparam logic [OUT_W-1:0] HIDDEN_MASK = {{(OUT_W-1){1'b0}}, 1'b1} << HIDDEN_POS;

  logic [OUT_W-1:0]        exp_ext;
  logic [OUT_W-1:0]        frac_ext;
  logic [OUT_W-1:0]        frac_aligned;
  logic signed [OUT_W-1:0] unbiased;

  assign exp_ext      = {{(OUT_W-EXP_W){1'b0}}, exp_field};
  assign frac_ext     = {{(OUT_W-FRAC_W){1'b0}}, frac_field};
  assign frac_aligned = frac_ext << ALIGN;
  assign unbiased     = $signed(exp_ext) - BIAS;

  always_comb begin
    unique case (op_class)
      CLS_SPECIAL: begin
        exponent = exp_ext;
        mantissa = frac_aligned;
      end
      CLS_ZERO: begin
        exponent = OUT_W'(-BIAS);
        mantissa = '0;
      end
      CLS_SUBNORM: begin
        exponent = OUT_W'(BIAS * -1 + 1);
        mantissa = frac_aligned;
      end
      default: begin
        exponent = unbiased;
        mantissa = frac_aligned | HIDDEN_MASK;
      end
    endcase
  end
endmodule

// File: rtl/fp_stream_reg.sv
module fp_stream_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (load)     out_data  <= in_data;
    end
  end
endmodule

// File: rtl/fp_unpack_unit.sv
module fp_unpack_unit
  import fp_unpack_pkg::*;
#(
  parameter int EXP_W      = 8,
  parameter int FRAC_W     = 23,
  parameter int OUT_W      = 32,
  parameter int HIDDEN_POS = 30
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [EXP_W+FRAC_W:0]     in_operand,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [OUT_W-1:0]          out_exponent,
  output logic [OUT_W-1:0]          out_mantissa
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic              sign_unused;
  logic [EXP_W-1:0]  exp_field;
  logic [FRAC_W-1:0] frac_field;
  op_class_e         op_class;
  logic [OUT_W-1:0]  exp_word;
  logic [OUT_W-1:0]  mant_word;
  logic [2*OUT_W-1:0] pair_q;

  // The sign never reaches the result words
  assign sign_unused = in_operand[MAG_W];

  fp_field_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_decode (
    .magnitude  (in_operand[MAG_W-1:0]),
    .exp_field  (exp_field),
    .frac_field (frac_field),
    .op_class   (op_class)
  );

  fp_value_build #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .HIDDEN_POS(HIDDEN_POS)
  ) u_build (
    .op_class   (op_class),
    .exp_field  (exp_field),
    .frac_field (frac_field),
    .exponent   (exp_word),
    .mantissa   (mant_word)
  );

  fp_stream_reg #(.W(2*OUT_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({exp_word, mant_word}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pair_q)
  );

  assign out_exponent = pair_q[2*OUT_W-1:OUT_W];
  assign out_mantissa = pair_q[OUT_W-1:0];
endmodule

// File: rtl/fp_unpack_checker.sv
module fp_unpack_checker #(
  parameter int OUT_W      = 32,
  parameter int HIDDEN_POS = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_exponent,
  input logic [OUT_W-1:0] out_mantissa
);
  // R7: a stalled result is frozen
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_exponent) && $stable(out_mantissa));

  // R7: no operand is taken over a stalled result
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R6: accepted operand shows up after one edge
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R5: top mantissa bit stays clear
  a_r5_mant_top: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_mantissa[OUT_W-1]);

  // R2: exponent -127 only comes with an empty mantissa
  a_r2_zero_mant: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($signed(out_exponent) == -127) |-> out_mantissa == '0);

  // R1: exponent 255 never carries the hidden bit
  a_r1_no_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_exponent == OUT_W'(255)) |-> !out_mantissa[HIDDEN_POS]);

  // R4: hidden bit implies a normal exponent range
  a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mantissa[HIDDEN_POS] |->
      ($signed(out_exponent) >= -126) && ($signed(out_exponent) <= 127));

  // R8: reset empties the output stage
  a_r8_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind fp_unpack_unit fp_unpack_checker #(.OUT_W(OUT_W), .HIDDEN_POS(HIDDEN_POS)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_exponent (out_exponent),
  .out_mantissa (out_mantissa)
);

// File: tb/test_fp_unpack_unit.sv
module test_fp_unpack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_exponent;
  logic [31:0] out_mantissa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_unpack_unit i_fp_unpack_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_operand,
    .out_valid, .out_ready, .out_exponent, .out_mantissa
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Expected words computed from the field rules
  task automatic model(input logic [31:0] op, output logic [31:0] e_o, output logic [31:0] m_o,
                       output string req);
    int e = int'(op[30:23]);
    int f = int'(op[22:0]);
    if (e == 255) begin
      e_o = 32'd255; m_o = f * 128; req = "R1";
    end else if (e == 0 && f == 0) begin
      e_o = -127; m_o = 0; req = "R2";
    end else if (e == 0) begin
      e_o = -126; m_o = f * 128; req = "R3";
    end else begin
      e_o = e - 127; m_o = f * 128 + (1 << 30); req = "R4";
    end
  endtask

  // One operand through an always-ready consumer; returns the words seen
  task automatic send(input logic [31:0] op, output logic [31:0] e_seen, output logic [31:0] m_seen);
    in_operand = op;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", {31'd0, out_valid}, 32'd1);
    e_seen = out_exponent;
    m_seen = out_mantissa;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] fracs [5];
    logic [31:0] e_exp, m_exp, e0, m0, e1, m1;
    string req;
    fracs[0] = 32'h0; fracs[1] = 32'h1; fracs[2] = 32'h7FFFFF;
    fracs[3] = 32'h400000; fracs[4] = 32'h2AAAAA;

    // R8: state while reset is held
    repeat (3) @(negedge clk);
    check("R8", {31'd0, out_valid}, 32'd0);
    check("R8", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R5: sweep every exponent field value
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 5; k++) begin
        logic [31:0] op;
        op = {1'b0, 8'(e), fracs[k][22:0]};
        model(op, e_exp, m_exp, req);
        send(op, e0, m0);
        check(req, e0, e_exp);
        check(req, m0, m_exp);
        send(op | 32'h8000_0000, e1, m1);
        check("R5 sign exp", e1, e0);
        check("R5 sign mant", m1, m0);
        check("R5 zero bits", m1 & 32'h8000_007F, 32'd0);
      end
    end
    @(negedge clk);
    check("R6 drain", {31'd0, out_valid}, 32'd0);

    // R7: stall with a waiting operand
    out_ready  = 1'b0;
    in_operand = 32'h3F80_0000;
    in_valid   = 1'b1;
    @(negedge clk);
    in_operand = 32'h4000_0000;
    repeat (3) begin
      @(negedge clk);
      check("R7 held valid", {31'd0, out_valid}, 32'd1);
      check("R7 ready low", {31'd0, in_ready}, 32'd0);
      check("R7 held exp", out_exponent, 32'd0);
      check("R7 held mant", out_mantissa, 32'h4000_0000);
    end
    out_ready = 1'b1;
    #0;
    check("R7 ready back", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 next valid", {31'd0, out_valid}, 32'd1);
    check("R7 next exp", out_exponent, 32'd1);
    check("R7 next mant", out_mantissa, 32'h4000_0000);
    @(negedge clk);
    check("R6 empty", {31'd0, out_valid}, 32'd0);

    // R8: reset clears a pending result
    out_ready  = 1'b0;
    in_operand = 32'h0;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    check("R8 cleared", {31'd0, out_valid}, 32'd0);
    rst_n     = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule